// File: doc/BRIEF.md
# Variable-Length Instruction Pre-Decoder

This block sits between instruction fetch and execute in a core whose instructions are one to seven bytes long. Each cycle it may accept a window of seven bytes, lowest-addressed byte first, together with the address of that first byte. From the opcode byte, and in one family from the byte after it, it decides how long the instruction is. It then repacks the operand bytes into a fixed 32-bit main word and a 24-bit extension word, so the execute stage always finds fields in the same place. Some operand halfwords and words arrive least-significant byte first and are swapped on the way.

The result is registered and appears one clock after the window is accepted. With it come the decoded length, a flag for an opcode with no defined encoding, and the address of the following instruction. Fetch uses that address to advance. When no window is offered, the registered fields keep their last values and the output valid drops.

The byte window is `win_i`, with the byte at `pc_i` in bits 7:0 and the byte at `pc_i+k` in bits 8k+7:8k. Below, b0..b6 name those bytes, and `{a,b,..}` lists bytes from the most significant end.

Top module: `vlen_predecode`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it, `out_valid_o`, `len_o`, `insn_o`, `ext_o`, `illegal_o` and `next_pc_o` are all zero.
- R2: `out_valid_o` equals `in_valid_i` of the previous cycle. After a cycle without `in_valid_i`, `len_o`, `insn_o`, `ext_o`, `illegal_o` and `next_pc_o` keep their previous values.
- R3: Single-byte opcodes give length 1, `insn_o = {0,0,0,b0}` and `ext_o = 0`. These are 00, 04, 08, 0C, 10–1F, 3C–3F, 40, 41, 44, 45, 48, 49, 4C, 4D, 50–57, 60–7F, CB, D0–DB, E0–EF and FF.
- R4: In the range 80–BF, an opcode whose bits 3:2 equal its bits 1:0 is two bytes long, with `insn_o = {0,0,b0,b1}`. Every other opcode in that range is one byte long, laid out as in R3.
- R5: Opcodes 20–23, 28–2B, 42, 43, 46, 47, 4A, 4B, 4E, 4F, 58–5F, C0–CA, CE, CF and F0–F6 give length 2, `insn_o = {0,0,b0,b1}` and `ext_o = 0`.
- R6: Opcodes 01–03, 05–07, 09–0B, 0D–0F, 24–27, 2C–3B and CC give length 3, `insn_o = {0,b0,b2,b1}` and `ext_o = 0`. The operand is a little-endian halfword.
- R7: Opcodes DE, DF, F8 and F9 give length 3, `insn_o = {0,b0,b1,b2}` and `ext_o = 0`.
- R8: Opcodes FA and FB give length 4 and `ext_o = 0`. When `{b0,b1} & FFFC` is FAF0, FAF4 or FAF8, `insn_o = {b0,b1,b2,b3}`. Otherwise `insn_o = {b0,b1,b3,b2}`.
- R9: Opcode CD gives length 5, `insn_o = {b0,b2,b1,b3}` and `ext_o = {0,0,b4}`. Opcode DC gives length 5, `insn_o = {b0,b4,b3,b2}` and `ext_o = {0,0,b1}`.
- R10: Opcodes FC and FD give length 6, `insn_o = {b0,b1,b5,b4}` and `ext_o = {0,b3,b2}`.
- R11: Opcode DD gives length 7, `insn_o = {b0,b4,b3,b2}` and `ext_o = {b1,b5,b6}`. Opcode FE gives length 7, `insn_o = {b0,b1,b5,b4}` and `ext_o = {b3,b2,b6}`.
- R12: F7 is the only opcode outside the map. For it, `illegal_o = 1`, length is 1, `insn_o = {0,0,0,b0}` and `ext_o = 0`. For every other opcode, `illegal_o = 0`.
- R13: `next_pc_o` equals the accepted `pc_i` plus the decoded length, modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Window and address are offered this cycle |
| pc_i | input | PC_W | Address of byte b0 |
| win_i | input | 56 | Seven instruction bytes, b0 in bits 7:0 |
| out_valid_o | output | 1 | Registered fields belong to an accepted window |
| len_o | output | 3 | Instruction length in bytes |
| insn_o | output | 32 | Repacked main instruction word |
| ext_o | output | 24 | Repacked extension word |
| illegal_o | output | 1 | Opcode has no defined encoding |
| next_pc_o | output | PC_W | Address of the following instruction |

## Verification
The bench builds the block with the default 32-bit address width. At that width, a window placed two bytes below the top of the address space makes the next-address sum wrap, which exercises the modulo rule of R13. Every opcode value is also driven once, so the single undefined opcode and the full register-equality pattern in 80–BF are covered exhaustively. The word-layout cases use distinct byte values, so any swapped or misplaced byte shows up in the repacked words.

// File: rtl/vlp_pkg.sv
package vlp_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned WIN_BYTES = 7;
    localparam int unsigned WIN_W     = BYTE_W * WIN_BYTES;
    localparam int unsigned INSN_W    = 32;
    localparam int unsigned EXT_W     = 24;
    localparam int unsigned LEN_W     = $clog2(WIN_BYTES + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    // Shape of an instruction: length plus field layout
    typedef enum logic [3:0] {
        SH_ONE,
        SH_TWO,
        SH_THREE_LE,
        SH_THREE_BE,
        SH_FOUR,
        SH_FIVE_A,
        SH_FIVE_B,
        SH_SIX,
        SH_SEVEN_A,
        SH_SEVEN_B,
        SH_BAD
    } shape_e;

    typedef struct packed {
        logic              vld;
        logic [LEN_W-1:0]  len;
        logic              ill;
        logic [INSN_W-1:0] insn;
        logic [EXT_W-1:0]  ext;
    } dec_t;

    function automatic logic [LEN_W-1:0] shape_len(input shape_e sh);
        case (sh)
            SH_TWO:                 return LEN_W'(2);
            SH_THREE_LE,
            SH_THREE_BE:            return LEN_W'(3);
            SH_FOUR:                return LEN_W'(4);
            SH_FIVE_A, SH_FIVE_B:   return LEN_W'(5);
            SH_SIX:                 return LEN_W'(6);
            SH_SEVEN_A, SH_SEVEN_B: return LEN_W'(7);
            default:                return LEN_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/vlp_shape_class.sv
module vlp_shape_class
    import vlp_pkg::*;
(
    input  byte_t  op_i,
    output shape_e shape_o
);

    always_comb begin
        shape_o = SH_BAD;
        case (op_i) inside
            // register-equality pairs in this range decode as two bytes
            [8'h80:8'hBF]:
                shape_o = (op_i[3:2] == op_i[1:0]) ? SH_TWO : SH_ONE;
            8'h00, 8'h04, 8'h08, 8'h0C, [8'h10:8'h1F], [8'h3C:8'h3F],
            8'h40, 8'h41, 8'h44, 8'h45, 8'h48, 8'h49, 8'h4C, 8'h4D,
            [8'h50:8'h57], [8'h60:8'h7F], 8'hCB, [8'hD0:8'hDB],
            [8'hE0:8'hEF], 8'hFF:
                shape_o = SH_ONE;
            [8'h20:8'h23], [8'h28:8'h2B], 8'h42, 8'h43, 8'h46, 8'h47,
            8'h4A, 8'h4B, 8'h4E, 8'h4F, [8'h58:8'h5F], [8'hC0:8'hCA],
            8'hCE, 8'hCF, [8'hF0:8'hF6]:
                shape_o = SH_TWO;
            [8'h01:8'h03], [8'h05:8'h07], [8'h09:8'h0B], [8'h0D:8'h0F],
            [8'h24:8'h27], [8'h2C:8'h3B], 8'hCC:
                shape_o = SH_THREE_LE;
            8'hDE, 8'hDF, 8'hF8, 8'hF9:
                shape_o = SH_THREE_BE;
            8'hFA, 8'hFB:
                shape_o = SH_FOUR;
            8'hCD:
                shape_o = SH_FIVE_A;
            8'hDC:
                shape_o = SH_FIVE_B;
            8'hFC, 8'hFD:
                shape_o = SH_SIX;
            8'hDD:
                shape_o = SH_SEVEN_A;
            8'hFE:
                shape_o = SH_SEVEN_B;
            default:
                shape_o = SH_BAD;
        endcase
    end

endmodule

// File: rtl/vlp_field_pack.sv
module vlp_field_pack
    import vlp_pkg::*;
(
    input  shape_e            shape_i,
    input  logic [WIN_W-1:0]  win_i,
    output logic [INSN_W-1:0] insn_o,
    output logic [EXT_W-1:0]  ext_o
);

    byte_t b [WIN_BYTES];

    for (genvar gi = 0; gi < WIN_BYTES; gi++) begin : g_unpack
        assign b[gi] = win_i[gi*BYTE_W +: BYTE_W];
    end

    // four-byte family: a few second-byte patterns are taken in address order
    logic wide_be;
    assign wide_be = (b[0] == 8'hFA) && (b[1][7:2] inside {6'h3C, 6'h3D, 6'h3E});

    always_comb begin
        insn_o = '0;
        ext_o  = '0;
        case (shape_i)
            SH_TWO:      insn_o = {16'h0000, b[0], b[1]};
            SH_THREE_LE: insn_o = {8'h00, b[0], b[2], b[1]};
            SH_THREE_BE: insn_o = {8'h00, b[0], b[1], b[2]};
            SH_FOUR:     insn_o = wide_be ? {b[0], b[1], b[2], b[3]}
                                          : {b[0], b[1], b[3], b[2]};
            SH_FIVE_A: begin
                insn_o = {b[0], b[2], b[1], b[3]};
                ext_o  = {16'h0000, b[4]};
            end
            SH_FIVE_B: begin
                insn_o = {b[0], b[4], b[3], b[2]};
                ext_o  = {16'h0000, b[1]};
            end
            SH_SIX: begin
                insn_o = {b[0], b[1], b[5], b[4]};
                ext_o  = {8'h00, b[3], b[2]};
            end
            SH_SEVEN_A: begin
                insn_o = {b[0], b[4], b[3], b[2]};
                ext_o  = {b[1], b[5], b[6]};
            end
            SH_SEVEN_B: begin
                insn_o = {b[0], b[1], b[5], b[4]};
                ext_o  = {b[3], b[2], b[6]};
            end
            default:     insn_o = {24'h000000, b[0]};
        endcase
    end

endmodule

// File: rtl/vlen_predecode.sv
module vlen_predecode
    import vlp_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              in_valid_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [55:0]       win_i,
    output logic              out_valid_o,
    output logic [2:0]        len_o,
    output logic [31:0]       insn_o,
    output logic [23:0]       ext_o,
    output logic              illegal_o,
    output logic [PC_W-1:0]   next_pc_o
);

    shape_e            shape;
    logic [INSN_W-1:0] insn_pk;
    logic [EXT_W-1:0]  ext_pk;

    vlp_shape_class u_class (
        .op_i    (win_i[BYTE_W-1:0]),
        .shape_o (shape)
    );

    vlp_field_pack u_pack (
        .shape_i (shape),
        .win_i   (win_i),
        .insn_o  (insn_pk),
        .ext_o   (ext_pk)
    );

    dec_t            dec_d, dec_q;
    logic [PC_W-1:0] npc_d, npc_q;

    always_comb begin
        dec_d     = dec_q;
        npc_d     = npc_q;
        dec_d.vld = in_valid_i;
        if (in_valid_i) begin
            dec_d.len  = shape_len(shape);
            dec_d.ill  = (shape == SH_BAD);
            dec_d.insn = insn_pk;
            dec_d.ext  = ext_pk;
            npc_d      = pc_i + PC_W'(shape_len(shape));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dec_q <= '0;
            npc_q <= '0;
        end else begin
            dec_q <= dec_d;
            npc_q <= npc_d;
        end
    end

    assign out_valid_o = dec_q.vld;
    assign len_o       = dec_q.len;
    assign insn_o      = dec_q.insn;
    assign ext_o       = dec_q.ext;
    assign illegal_o   = dec_q.ill;
    assign next_pc_o   = npc_q;

endmodule

// File: rtl/vlen_predecode_chk.sv
module vlen_predecode_chk #(
    parameter int unsigned PC_W = 32
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            in_valid_i,
    input logic [PC_W-1:0] pc_i,
    input logic            out_valid_o,
    input logic [2:0]      len_o,
    input logic [31:0]     insn_o,
    input logic [23:0]     ext_o,
    input logic            illegal_o,
    input logic [PC_W-1:0] next_pc_o
);

    p_valid_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);

    p_valid_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);

    p_hold_fields_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> ($stable(insn_o) && $stable(ext_o) && $stable(len_o)));

    p_len_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> (len_o >= 3'd1 && len_o <= 3'd7));

    p_short_no_ext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && len_o <= 3'd4) |-> (ext_o == 24'h0));

    p_single_narrow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && len_o == 3'd1) |-> (insn_o[31:8] == 24'h0));

    p_illegal_len_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && illegal_o) |-> (len_o == 3'd1));

    p_next_pc_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> (next_pc_o == $past(pc_i) + PC_W'(len_o)));

endmodule

bind vlen_predecode vlen_predecode_chk #(.PC_W(PC_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .pc_i        (pc_i),
    .out_valid_o (out_valid_o),
    .len_o       (len_o),
    .insn_o      (insn_o),
    .ext_o       (ext_o),
    .illegal_o   (illegal_o),
    .next_pc_o   (next_pc_o)
);

// File: tb/vlen_predecode_test.sv
`timescale 1ns/1ps
module vlen_predecode_test;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [PC_W-1:0] pc = '0;
    logic [55:0]     win = '0;
    logic            out_valid;
    logic [2:0]      len;
    logic [31:0]     insn;
    logic [23:0]     ext;
    logic            illegal;
    logic [PC_W-1:0] next_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vlen_predecode #(.PC_W(PC_W)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .in_valid_i  (in_valid),
        .pc_i        (pc),
        .win_i       (win),
        .out_valid_o (out_valid),
        .len_o       (len),
        .insn_o      (insn),
        .ext_o       (ext),
        .illegal_o   (illegal),
        .next_pc_o   (next_pc)
    );

    function automatic logic [55:0] mkwin(input logic [7:0] b0);
        return {8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11, b0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one window, let it register, sample away from the edge
    task automatic issue(input logic [PC_W-1:0] a, input logic [55:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        pc       = a;
        win      = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_dec(input string req, input logic [2:0] el,
                              input logic [31:0] ei, input logic [23:0] ee,
                              input logic eill);
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check({req, " len"}, 64'(len), 64'(el));
        check({req, " insn"}, 64'(insn), 64'(ei));
        check({req, " ext"}, 64'(ext), 64'(ee));
        check({req, " illegal"}, 64'(illegal), 64'(eill));
    endtask

    task automatic t_reset_r1();
        check("R1 valid", 64'(out_valid), 64'd0);
        check("R1 len", 64'(len), 64'd0);
        check("R1 insn", 64'(insn), 64'd0);
        check("R1 ext", 64'(ext), 64'd0);
        check("R1 next_pc", 64'(next_pc), 64'd0);
    endtask

    task automatic t_one_byte_r3();
        issue(32'h100, mkwin(8'h6A));
        expect_dec("R3 6A", 3'd1, 32'h0000006A, 24'h0, 1'b0);
        issue(32'h100, mkwin(8'hCB));
        expect_dec("R3 CB", 3'd1, 32'h000000CB, 24'h0, 1'b0);
    endtask

    task automatic t_equal_regs_r4();
        int bad = 0;
        issue(32'h100, mkwin(8'h85));
        expect_dec("R4 85", 3'd2, 32'h00008511, 24'h0, 1'b0);
        issue(32'h100, mkwin(8'h86));
        expect_dec("R4 86", 3'd1, 32'h00000086, 24'h0, 1'b0);
        for (int op = 8'h80; op <= 8'hBF; op++) begin
            logic [7:0] o;
            logic [2:0] el;
            o  = 8'(op);
            el = (o[3:2] == o[1:0]) ? 3'd2 : 3'd1;
            issue(32'h0, mkwin(o));
            if (len !== el) bad++;
        end
        check("R4 sweep mismatches", 64'(bad), 64'd0);
    endtask

    task automatic t_two_byte_r5();
        issue(32'h100, mkwin(8'hF0));
        expect_dec("R5 F0", 3'd2, 32'h0000F011, 24'h0, 1'b0);
        issue(32'h100, mkwin(8'h5C));
        expect_dec("R5 5C", 3'd2, 32'h00005C11, 24'h0, 1'b0);
    endtask

    task automatic t_three_r6_r7();
        issue(32'h100, mkwin(8'h2C));
        expect_dec("R6 2C", 3'd3, 32'h002C2211, 24'h0, 1'b0);
        issue(32'h100, mkwin(8'hCC));
        expect_dec("R6 CC", 3'd3, 32'h00CC2211, 24'h0, 1'b0);
        issue(32'h100, mkwin(8'hDE));
        expect_dec("R7 DE", 3'd3, 32'h00DE1122, 24'h0, 1'b0);
    endtask

    task automatic t_four_r8();
        issue(32'h100, {8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'hF5, 8'hFA});
        expect_dec("R8 FAF5 in order", 3'd4, 32'hFAF52233, 24'h0, 1'b0);
        issue(32'h100, mkwin(8'hFA));
        expect_dec("R8 FA11 swapped", 3'd4, 32'hFA113322, 24'h0, 1'b0);
        issue(32'h100, {8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'hF0, 8'hFB});
        expect_dec("R8 FBF0 swapped", 3'd4, 32'hFBF03322, 24'h0, 1'b0);
        issue(32'h100, {8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'hFC, 8'hFA});
        expect_dec("R8 FAFC swapped", 3'd4, 32'hFAFC3322, 24'h0, 1'b0);
    endtask

    task automatic t_long_r9_r10_r11();
        issue(32'h100, mkwin(8'hCD));
        expect_dec("R9 CD", 3'd5, 32'hCD221133, 24'h000044, 1'b0);
        issue(32'h100, mkwin(8'hDC));
        expect_dec("R9 DC", 3'd5, 32'hDC443322, 24'h000011, 1'b0);
        issue(32'h100, mkwin(8'hFD));
        expect_dec("R10 FD", 3'd6, 32'hFD115544, 24'h003322, 1'b0);
        issue(32'h100, mkwin(8'hDD));
        expect_dec("R11 DD", 3'd7, 32'hDD443322, 24'h115566, 1'b0);
        issue(32'h100, mkwin(8'hFE));
        expect_dec("R11 FE", 3'd7, 32'hFE115544, 24'h332266, 1'b0);
    endtask

    task automatic t_illegal_r12();
        int nill = 0;
        issue(32'h100, mkwin(8'hF7));
        expect_dec("R12 F7", 3'd1, 32'h000000F7, 24'h0, 1'b1);
        for (int op = 0; op < 256; op++) begin
            issue(32'h0, mkwin(8'(op)));
            if (illegal === 1'b1) nill++;
        end
        check("R12 illegal count", 64'(nill), 64'd1);
    endtask

    task automatic t_next_pc_r13();
        issue(32'h0000_1000, mkwin(8'hDC));
        check("R13 next_pc +5", 64'(next_pc), 64'h1005);
        issue(32'hFFFF_FFFE, mkwin(8'hFE));
        check("R13 next_pc wrap", 64'(next_pc), 64'h5);
    endtask

    task automatic t_hold_r2();
        issue(32'h200, mkwin(8'hDD));
        @(negedge clk);
        win = mkwin(8'h01);
        pc  = 32'h999;
        @(negedge clk);
        @(negedge clk);
        check("R2 valid low", 64'(out_valid), 64'd0);
        check("R2 insn held", 64'(insn), 64'hDD443322);
        check("R2 ext held", 64'(ext), 64'h115566);
        check("R2 next_pc held", 64'(next_pc), 64'h207);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_r1();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_r1();
        t_one_byte_r3();
        t_equal_regs_r4();
        t_two_byte_r5();
        t_three_r6_r7();
        t_four_r8();
        t_long_r9_r10_r11();
        t_illegal_r12();
        t_next_pc_r13();
        t_hold_r2();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

endmodule